// File: doc/BRIEF.md
# Segmented 14-bit PWM generator

The block turns sixteen 16-bit display words into sixteen gray-scale on/off enables, all timed by one shared gray-scale clock. A 14-bit frame counter splits each 16384-clock frame into four sub-cycles of 4096 clocks. In every sub-cycle a channel is on from the start of the sub-cycle for as many clocks as bits [13:2] of its word give. Bits [1:0] add one more on-clock to the first one, two or three sub-cycles. This spreads the light of one frame over four shorter pulses and lifts the visible refresh rate.

New words wait on a pending input bus. A one-clock latch pulse copies them into the active buffer and restarts the frame at count 0, whatever the count was. A mode input picks what happens at the end of a frame. In one-shot mode the frame is played once and the outputs go dark. In repeat mode the same active words are played again, frame after frame, until the next latch.

Top module: `seg_pwm_gen`

## Requirements
- R1: A running frame lasts exactly 16384 clocks. The counter steps by one each clock, and bits [13:12] of the count select one of four 4096-clock sub-cycles.
- R2: Within each sub-cycle a channel is on from position 0 of that sub-cycle. It stays on for N clocks, where N is bits [13:2] of its active word plus that sub-cycle's insert clock, and is off for the rest of the sub-cycle.
- R3: The insert field is bits [1:0]. Value 0 adds no clock. Value 1 adds a clock to sub-cycle 1. Value 2 adds a clock to sub-cycles 1 and 2. Value 3 adds a clock to sub-cycles 1, 2 and 3. Sub-cycle 4 never gets one.
- R4: Bits [15:14] of a word have no effect on its output.
- R5: Word 0x3FFF gives 4096, 4096, 4096 and 4095 on-clocks in sub-cycles 1 to 4. Word 0x0003 gives 1, 1, 1 and 0. Word 0x0000 keeps the channel off.
- R6: A latch pulse loads all pending words into the active buffer and restarts the frame at count 0 on that edge, even in the middle of a frame.
- R7: With the mode input low (one-shot), the counter stops after the last clock of the frame. All outputs then stay low until the next latch, and changes on the pending bus have no effect.
- R8: With the mode input high (repeat), a frame that ends without a latch is followed at once by a new frame. The new frame uses the same active words, and the pending bus is not taken.
- R9: After reset the counter is idle, all outputs are low, all buffers are zero, and nothing lights before the first latch.
- R10: Outputs are registered. The enables for count k appear one clock after the edge at which the counter holds k, so outputs are still low just after the latch edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Gray-scale clock |
| rst_n | input | 1 | Active-low synchronous reset |
| latch_i | input | 1 | Global latch pulse: load pending words, restart frame |
| auto_mode_i | input | 1 | 0 = one-shot frame, 1 = repeat frame |
| pend_data_i | input | 256 | Pending words, channel c at bits [16c+15:16c] |
| chan_en_o | output | 16 | Active-high channel enables |

## Verification
The bound checker watches the frame sequencing on every cycle: the counter steps by one, a latch restarts it at zero, a one-shot frame stops at the last count, a repeat frame wraps, and an idle counter gives dark outputs on the next clock. The on-time shape of each channel cannot be seen by those properties. That shape is the split into four sub-cycles, the insert pattern, the corner words and the reserved bits being ignored. The bench scenarios show it by comparing every output sample of whole frames with a value computed from the word. The bench also shows that the pending bus is ignored in repeat and idle states, and that a latch in mid-frame restarts the frame.

// File: rtl/seg_pwm_gen.sv
module seg_pwm_gen #(
  parameter int CHANNELS = 16,
  parameter int WORD_W   = 16,
  parameter int SUB_W    = 12,
  parameter int SEG_BITS = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       latch_i,
  input  logic                       auto_mode_i,
  input  logic [CHANNELS*WORD_W-1:0] pend_data_i,
  output logic [CHANNELS-1:0]        chan_en_o
);

  localparam int CNT_W = SUB_W + SEG_BITS;
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [CNT_W-1:0]    frame_cnt;
  logic                running;
  logic [SEG_BITS-1:0] seg;
  logic [SUB_W-1:0]    pos;

  assign seg = frame_cnt[CNT_W-1 -: SEG_BITS];
  assign pos = frame_cnt[SUB_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_cnt <= '0;
      running   <= 1'b0;
    end else if (latch_i) begin
      frame_cnt <= '0;
      running   <= 1'b1;
    end else if (running) begin
      if (frame_cnt == CNT_LAST) begin
        frame_cnt <= '0;
        running   <= auto_mode_i;
      end else begin
        frame_cnt <= frame_cnt + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
    logic [CNT_W-1:0]    act;
    logic [SUB_W:0]      limit;
    logic                ins_hit;
    logic                unused_rsvd;

    assign unused_rsvd = ^pend_data_i[g*WORD_W+CNT_W +: WORD_W-CNT_W];

    always_ff @(posedge clk) begin
      if (!rst_n)       act <= '0;
      else if (latch_i) act <= pend_data_i[g*WORD_W +: CNT_W];
    end

    assign ins_hit = seg < act[SEG_BITS-1:0];
    assign limit   = {1'b0, act[SEG_BITS +: SUB_W]} + {{SUB_W{1'b0}}, ins_hit};

    always_ff @(posedge clk) begin
      if (!rst_n) chan_en_o[g] <= 1'b0;
      else        chan_en_o[g] <= running && ({1'b0, pos} < limit);
    end
  end

endmodule

// File: rtl/seg_pwm_chk.sv
module seg_pwm_chk #(
  parameter int CHANNELS = 16,
  parameter int CNT_W    = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic                latch_i,
  input logic                auto_mode_i,
  input logic [CNT_W-1:0]    frame_cnt,
  input logic                running,
  input logic [CHANNELS-1:0] chan_en_o
);

  localparam logic [CNT_W-1:0] LAST = '1;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !latch_i && frame_cnt != LAST) |=> (running && frame_cnt == $past(frame_cnt) + 1'b1)); // R1

  AST_LATCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    latch_i |=> (running && frame_cnt == '0)); // R6

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !latch_i && !auto_mode_i && frame_cnt == LAST) |=> !running); // R7

  AST_REPEAT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !latch_i && auto_mode_i && frame_cnt == LAST) |=> (running && frame_cnt == '0)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !latch_i) |=> !running); // R7

  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (chan_en_o == '0)); // R9

endmodule

bind seg_pwm_gen seg_pwm_chk #(.CHANNELS(CHANNELS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .latch_i(latch_i), .auto_mode_i(auto_mode_i),
  .frame_cnt(frame_cnt), .running(running), .chan_en_o(chan_en_o)
);

// File: tb/tb_seg_pwm_gen.sv
module tb_seg_pwm_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 16;
  localparam int FRAME = 16384;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic latch_i = 1'b0;
  logic auto_mode_i = 1'b0;
  logic [CH*16-1:0] pend_data_i = '0;
  logic [CH-1:0] chan_en_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_w [CH];

  seg_pwm_gen dut (
    .clk(clk), .rst_n(rst_n), .latch_i(latch_i), .auto_mode_i(auto_mode_i),
    .pend_data_i(pend_data_i), .chan_en_o(chan_en_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [15:0] w, input int k);
    int sub = k / 4096;
    int p   = k % 4096;
    int on  = int'(w[13:2]) + ((sub < int'(w[1:0])) ? 1 : 0);
    return p < on;
  endfunction

  task automatic load_pend(input logic [15:0] w [CH]);
    for (int c = 0; c < CH; c++) pend_data_i[c*16 +: 16] = w[c];
  endtask

  task automatic pulse_latch();
    @(negedge clk) latch_i = 1'b1;
    @(posedge clk);
    @(negedge clk) latch_i = 1'b0;
  endtask

  task automatic run_frame(input string req, input string tag);
    int errs [CH];
    logic first_act [CH];
    int first_k [CH];
    for (int c = 0; c < CH; c++) begin errs[c] = 0; first_k[c] = -1; first_act[c] = 1'b0; end
    for (int k = 0; k < FRAME; k++) begin
      @(posedge clk);
      @(negedge clk);
      for (int c = 0; c < CH; c++) begin
        if (chan_en_o[c] !== exp_bit(exp_w[c], k)) begin
          if (errs[c] == 0) begin first_k[c] = k; first_act[c] = chan_en_o[c]; end
          errs[c]++;
        end
      end
    end
    for (int c = 0; c < CH; c++)
      check(errs[c] == 0, req, $sformatf("%s ch%0d word %h first bad count %0d", tag, c, exp_w[c], first_k[c]),
            {31'd0, first_act[c]}, {31'd0, ~first_act[c]});
  endtask

  task automatic expect_dark(input int cycles, input string req, input string tag);
    int bad = 0;
    logic [CH-1:0] seen = '0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (chan_en_o !== '0) begin bad++; seen = chan_en_o; end
    end
    check(bad == 0, req, tag, {16'd0, seen}, 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(chan_en_o == '0, "R9", "outputs during reset", {16'd0, chan_en_o}, 32'd0);
    rst_n = 1'b1;
    for (int c = 0; c < CH; c++) pend_data_i[c*16 +: 16] = 16'h3FFF;
    expect_dark(50, "R9", "no output before first latch");
  endtask

  task automatic t_basic();
    logic [15:0] w [CH] = '{16'h3FFF, 16'h0003, 16'h0000, 16'h1FFF, 16'h1FFE, 16'h1FFD,
                            16'h1FFC, 16'h0007, 16'h0006, 16'h0005, 16'h0004, 16'h3FF8,
                            16'hC005, 16'h8001, 16'h4ABC, 16'h0ABE};
    auto_mode_i = 1'b0;
    load_pend(w);
    exp_w = w;
    pulse_latch();
    check(chan_en_o == '0, "R10", "outputs still low right after latch edge", {16'd0, chan_en_o}, 32'd0);
    run_frame("R2 R3 R4 R5 R1", "one-shot frame");
  endtask

  task automatic t_oneshot_end();
    for (int c = 0; c < CH; c++) pend_data_i[c*16 +: 16] = 16'h2222;
    expect_dark(300, "R7", "one-shot dark after frame, pending change ignored");
  endtask

  task automatic t_repeat();
    logic [15:0] w [CH];
    for (int c = 0; c < CH; c++) w[c] = 16'(c * 1031 + 2);
    auto_mode_i = 1'b1;
    load_pend(w);
    exp_w = w;
    pulse_latch();
    run_frame("R2 R3", "repeat frame 1");
    for (int c = 0; c < CH; c++) pend_data_i[c*16 +: 16] = 16'h0001;
    run_frame("R8", "repeat frame 2 keeps held words");
  endtask

  task automatic t_midlatch();
    logic [15:0] w [CH];
    for (int c = 0; c < CH; c++) w[c] = 16'(16'h3FFF - c * 997);
    repeat (5000) @(posedge clk);
    load_pend(w);
    exp_w = w;
    pulse_latch();
    auto_mode_i = 1'b0;
    run_frame("R6", "restart after mid-frame latch");
    expect_dark(300, "R7", "dark after one-shot frame following repeat");
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_oneshot_end();
    t_repeat();
    t_midlatch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule